// File: doc/BRIEF.md
# Dual Alarm Interrupt Controller

This block keeps the two alarm interrupt flags of a real-time-clock register file and turns them into two active-low interrupt pins. An external time comparator pulses a match strobe for each alarm. The strobe latches that alarm's flag. Both flags can be read in a status byte.

The register file's address bus and its read and write strobes are watched. Any read or write that lands on one alarm's own registers clears that alarm's flag. No write-to-clear is needed.

Alarm 0 always signals on pin 0. A routing bit steers alarm 1 onto pin 1 or onto pin 0. When alarm 1 is steered onto pin 0, that pin is the OR of both sources.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: A match strobe high at a rising clock edge sets that alarm's flag, and the flag reads 1 from that edge on.
- R2: `status_byte` bit 0 is the alarm 0 flag and bit 1 is the alarm 1 flag. Bits 7 to 2 always read 0. The byte is readable at register index 10h.
- R3: `irq0_n` is low whenever the alarm 0 flag and `alarm0_irq_en` are both 1.
- R4: With `alarm1_to_pin1` = 1, the alarm 1 flag and `alarm1_irq_en` both at 1 drive `irq1_n` low. With `alarm1_to_pin1` = 0, the same condition drives `irq0_n` low and `irq1_n` stays high. On pin 0 this condition is ORed with the alarm 0 source.
- R5: With `alarm1_irq_en` = 0, the alarm 1 flag still sets and reads back, but it pulls neither pin low.
- R6: A read or a write to register index 07h through 0Ah clears the alarm 0 flag at the next edge. Indices 06h and 0Bh leave it unchanged.
- R7: A read or a write to register index 0Bh through 0Eh clears the alarm 1 flag at the next edge. Indices 0Ah and 0Fh leave it unchanged.
- R8: If a match strobe and a clearing access to that same alarm fall in one cycle, the flag is 1 after the edge.
- R9: While `rst_n` is low, both flags are 0 and both pins are high.
- R10: The register index is `reg_addr[6:0]`. Bit 7 marks a write view and does not affect decoding. A write to the status index (90h) or an access to any other unrelated index leaves both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| match0_stb | input | 1 | Alarm 0 time-match strobe |
| match1_stb | input | 1 | Alarm 1 time-match strobe |
| alarm0_irq_en | input | 1 | Lets alarm 0 reach a pin |
| alarm1_irq_en | input | 1 | Lets alarm 1 reach a pin |
| alarm1_to_pin1 | input | 1 | 1: alarm 1 drives pin 1; 0: alarm 1 drives pin 0 |
| reg_addr | input | 8 | Register address; bit 7 set for writes |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| status_byte | output | 8 | Status byte {6'b0, flag1, flag0} |
| irq0_n | output | 1 | Interrupt pin 0, active low |
| irq1_n | output | 1 | Interrupt pin 1, active low |

## Verification
The bench probes the edges of each alarm's address window: 06h, 0Ah, 0Bh, 0Eh and 0Fh. These are checked as both reads and writes. An off-by-one decoder would clear the wrong flag or miss a clear.

A match arriving in the same cycle as a clearing access is tested. A design that gives the clear priority would drop that alarm.

Routing is exercised with both flags active and alarm 1 steered onto pin 0. Clearing only flag 0 then must leave pin 0 low. A design that routes without the OR would release the pin early.

A write to the status index with both flags set checks that the status byte cannot be cleared by writing to it.

// File: rtl/alarm_irq_pkg.sv
// Shared constants for the dual alarm interrupt controller.
// Assumes register indices are 7 bits wide, with the write marker in bit 7.
package alarm_irq_pkg;
    localparam int ADDR_W      = 8;
    localparam int NUM_ALARM   = 2;
    localparam int REG_SPAN    = 4;
    localparam int FIRST_BASE  = 7;
    localparam int STATUS_IDX  = 16;
    localparam int STATUS_W    = 8;

    // Register index of the first register of alarm 'idx'
    function automatic int alarm_base(input int idx);
        return FIRST_BASE + idx * REG_SPAN;
    endfunction
endpackage

// File: rtl/alarm_range_decode.sv
// Flags an access (read or write) whose register index falls inside
// [BASE, BASE+SPAN). Assumes the top address bit is only a write marker.
module alarm_range_decode #(
    parameter int ADDR_W = 8,
    parameter int BASE   = 7,
    parameter int SPAN   = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              hit
);
    localparam int IDX_W = ADDR_W - 1;
    localparam int LAST  = BASE + SPAN - 1;

    logic [IDX_W-1:0] idx;
    assign idx = addr[IDX_W-1:0];

    // Window compare on the index, qualified by either strobe
    always_comb begin
        hit = (rd || wr) && (int'(idx) >= BASE) && (int'(idx) <= LAST);
    end
endmodule

// File: rtl/alarm_flag.sv
// Sticky flag for one alarm: set by a match, cleared by an access.
// Assumes set has priority over clear in the same cycle.
module alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_q
);
    // Flag register with set-over-clear priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end
endmodule

// File: rtl/irq_route.sv
// Combines flags and enables into two active-low pins. Alarm 1 is
// steered to pin 1 or ORed onto pin 0. Assumes quasi-static enables.
module irq_route (
    input  logic [1:0] flags,
    input  logic       en0,
    input  logic       en1,
    input  logic       to_pin1,
    output logic       pin0_n,
    output logic       pin1_n
);
    logic src0, src1;

    // Qualified interrupt sources and pin steering
    always_comb begin
        src0   = flags[0] && en0;
        src1   = flags[1] && en1;
        pin0_n = !(src0 || (src1 && !to_pin1));
        pin1_n = !(src1 && to_pin1);
    end
endmodule

// File: rtl/alarm_irq_ctrl.sv
// Top of the dual alarm interrupt controller. Each alarm gets a decoder
// and a sticky flag; the flags feed the status byte and the pin router.
// Assumes match strobes are synchronous to clk.
module alarm_irq_ctrl
    import alarm_irq_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          match0_stb,
    input  logic          match1_stb,
    input  logic          alarm0_irq_en,
    input  logic          alarm1_irq_en,
    input  logic          alarm1_to_pin1,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_rd,
    input  logic          reg_wr,
    output logic [STATUS_W-1:0] status_byte,
    output logic          irq0_n,
    output logic          irq1_n
);
    logic [NUM_ALARM-1:0] match_vec;
    logic [NUM_ALARM-1:0] hit_vec;
    logic [NUM_ALARM-1:0] flag_vec;

    assign match_vec = {match1_stb, match0_stb};

    // One decoder and one flag per alarm
    for (genvar g = 0; g < NUM_ALARM; g++) begin : g_alarm
        alarm_range_decode #(
            .ADDR_W(AW),
            .BASE  (alarm_base(g)),
            .SPAN  (REG_SPAN)
        ) u_dec (
            .addr(reg_addr),
            .rd  (reg_rd),
            .wr  (reg_wr),
            .hit (hit_vec[g])
        );
        alarm_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (match_vec[g]),
            .clr_i (hit_vec[g]),
            .flag_q(flag_vec[g])
        );
    end

    // Status byte: unused upper bits held at zero
    always_comb begin
        status_byte = '0;
        status_byte[NUM_ALARM-1:0] = flag_vec;
    end

    irq_route u_route (
        .flags  (flag_vec),
        .en0    (alarm0_irq_en),
        .en1    (alarm1_irq_en),
        .to_pin1(alarm1_to_pin1),
        .pin0_n (irq0_n),
        .pin1_n (irq1_n)
    );
endmodule

// File: rtl/alarm_irq_chk.sv
// Property checker for alarm_irq_ctrl, bound to every instance.
// Decodes alarm windows on its own from the address port.
module alarm_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       match0_stb,
    input logic       match1_stb,
    input logic       alarm0_irq_en,
    input logic       alarm1_irq_en,
    input logic       alarm1_to_pin1,
    input logic [7:0] reg_addr,
    input logic       reg_rd,
    input logic       reg_wr,
    input logic [7:0] status_byte,
    input logic       irq0_n,
    input logic       irq1_n
);
    logic acc, a0, a1;
    assign acc = reg_rd || reg_wr;
    assign a0  = acc && (reg_addr[6:0] inside {[7'h07:7'h0A]});
    assign a1  = acc && (reg_addr[6:0] inside {[7'h0B:7'h0E]});

    // R1
    set0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match0_stb |=> status_byte[0]);
    // R1
    set1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match1_stb |=> status_byte[1]);
    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[7:2] == 6'd0);
    // R3
    pin0_a0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm0_irq_en && status_byte[0]) |-> !irq0_n);
    // R4
    pin1_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm1_to_pin1 |-> irq1_n);
    // R4
    pin1_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm1_to_pin1 && alarm1_irq_en && status_byte[1]) |-> !irq1_n);
    // R5
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm1_irq_en && !(alarm0_irq_en && status_byte[0])) |-> (irq0_n && irq1_n));
    // R6
    clr0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a0 && !match0_stb) |=> !status_byte[0]);
    // R7
    clr1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a1 && !match1_stb) |=> !status_byte[1]);
    // R10
    hold0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a0 && !match0_stb) |=> $stable(status_byte[0]));
    // R10
    hold1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a1 && !match1_stb) |=> $stable(status_byte[1]));
endmodule

bind alarm_irq_ctrl alarm_irq_chk u_alarm_irq_chk (.*);

// File: tb/test_alarm_irq_ctrl.sv
`timescale 1ns/1ps
module test_alarm_irq_ctrl;
    logic clk = 0, rst_n = 0;
    logic m0 = 0, m1 = 0, en0 = 0, en1 = 0, steer = 0, rd = 0, wr = 0;
    logic [7:0] addr = 0;
    logic [7:0] st;
    logic i0n, i1n;
    int checks = 0, errors = 0;
    int f0 = 0, f1 = 0;
    bit done = 0;

    always #4 clk = ~clk;

    alarm_irq_ctrl i_alarm_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .match0_stb(m0), .match1_stb(m1),
        .alarm0_irq_en(en0), .alarm1_irq_en(en1), .alarm1_to_pin1(steer),
        .reg_addr(addr), .reg_rd(rd), .reg_wr(wr),
        .status_byte(st), .irq0_n(i0n), .irq1_n(i1n));

    // Behavioural reference: flags updated at each edge from requirements
    always @(posedge clk) begin
        int idx;
        bit acc;
        idx = addr & 8'h7f;
        acc = rd || wr;
        if (!rst_n) begin
            f0 = 0; f1 = 0;
        end else begin
            if (m0) f0 = 1; else if (acc && idx >= 7 && idx <= 10) f0 = 0;
            if (m1) f1 = 1; else if (acc && idx >= 11 && idx <= 14) f1 = 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Advance one cycle, then compare every output against the model
    task automatic cyc();
        int e0, e1;
        @(posedge clk);
        @(negedge clk);
        e0 = ((f0 && en0) || (f1 && en1 && !steer)) ? 0 : 1;
        e1 = (f1 && en1 && steer) ? 0 : 1;
        chk("R2 model status", st, f1 * 2 + f0);
        chk("R3/R4 model irq0_n", i0n, e0);
        chk("R4/R5 model irq1_n", i1n, e1);
    endtask

    task automatic access(input logic [7:0] a, input bit w);
        addr = a; rd = !w; wr = w;
        cyc();
        rd = 0; wr = 0; addr = 0;
    endtask

    task automatic pulse(input bit which);
        if (which) m1 = 1; else m0 = 1;
        cyc();
        m0 = 0; m1 = 0;
    endtask

    initial begin
        repeat (3) cyc();
        // R9: reset state with enables on
        en0 = 1; en1 = 1; steer = 1;
        cyc();
        chk("R9 status", st, 0);
        chk("R9 irq0_n", i0n, 1);
        chk("R9 irq1_n", i1n, 1);
        rst_n = 1;
        cyc();
        // R1 R3: alarm 0 sets and drives pin 0
        pulse(0);
        chk("R1 flag0", st[0], 1);
        chk("R3 irq0_n", i0n, 0);
        // R6 boundaries: 06h and 0Bh do not clear
        access(8'h06, 0);
        chk("R6 06h keeps", st[0], 1);
        access(8'h8B, 1);
        chk("R6 0Bh keeps", st[0], 1);
        access(8'h07, 0);
        chk("R6 read 07h clears", st[0], 0);
        pulse(0);
        access(8'h8A, 1);
        chk("R6 write 0Ah clears", st[0], 0);
        // R4: alarm 1 routed to pin 1, then pin 0
        pulse(1);
        chk("R4 irq1_n", i1n, 0);
        chk("R4 irq0_n quiet", i0n, 1);
        steer = 0;
        cyc();
        chk("R4 steered irq0_n", i0n, 0);
        chk("R4 steered irq1_n", i1n, 1);
        // R4: OR on pin 0, clear only flag 0
        pulse(0);
        access(8'h09, 0);
        chk("R4 or irq0_n", i0n, 0);
        chk("R4 flags", st, 8'h02);
        // R5: enable off, flag still readable
        en1 = 0;
        cyc();
        chk("R5 flag1", st[1], 1);
        chk("R5 irq0_n", i0n, 1);
        chk("R5 irq1_n", i1n, 1);
        // R7 boundaries
        access(8'h0A, 0);
        chk("R7 0Ah keeps", st[1], 1);
        access(8'h8F, 1);
        chk("R7 0Fh keeps", st[1], 1);
        access(8'h8E, 1);
        chk("R7 write 0Eh clears", st[1], 0);
        pulse(1);
        access(8'h0B, 0);
        chk("R7 read 0Bh clears", st[1], 0);
        // R8: set wins over same-cycle clear
        m0 = 1; addr = 8'h08; rd = 1;
        cyc();
        m0 = 0; rd = 0; addr = 0;
        chk("R8 set wins", st[0], 1);
        // R10: status write and read have no effect
        pulse(1);
        access(8'h90, 1);
        chk("R10 write 90h", st, 8'h03);
        access(8'h10, 0);
        chk("R2 read 10h", st, 8'h03);
        // Random mix against the model
        for (int n = 0; n < 400; n++) begin
            m0 = ($urandom_range(0, 7) == 0);
            m1 = ($urandom_range(0, 7) == 0);
            en0 = $urandom_range(0, 1); en1 = $urandom_range(0, 1);
            steer = $urandom_range(0, 1);
            addr = 8'($urandom_range(4, 17)) | (($urandom_range(0, 1) != 0) ? 8'h80 : 8'h00);
            rd = ($urandom_range(0, 3) == 0); wr = !rd && ($urandom_range(0, 3) == 0);
            cyc();
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule